// File: doc/BRIEF.md
# Dual Mode-Configurable Timer/Counter Pair

This block holds two timer/counter channels for an 8-bit microcontroller core. Each channel keeps a low count byte and a high count byte. It also has a run bit, a gate bit, a source-select bit and a two-bit mode field. A channel advances either on each machine-cycle enable pulse (timer) or on a falling edge of its external count pin (counter). The pin is sampled once per machine cycle. Counting can be qualified by an external gate pin, which lets software measure the width of a pulse on that pin.

Each channel has four modes: a 13-bit count with a 5-bit prescaler in the low byte, a full 16-bit count, an 8-bit count that reloads itself from the high byte, and a split mode. In split mode, channel 0 becomes two 8-bit counters, and its high half borrows channel 1's run bit and overflow flag. Channel 1 in split mode simply stops. Software loads every byte through a small synchronous write port. Overflow flags stay set until software writes them or the interrupt controller acknowledges them. The core reads both counts and both flags directly.

Top module: `dual_tmr_ctr`

## Requirements
- R1: When the synchronous active-low reset is applied, the reset value is zero for all four count bytes, both run bits, both overflow flags and the mode byte.
- R2: Mode 00 counts a 13-bit value. The high byte forms bits 12..5 and low-byte bits 4..0 form bits 4..0. Low-byte bits 7..5 keep their written value while the channel counts.
- R3: A channel advances only when its run bit is 1 and either its gate bit is 0 or its ext_int pin is 1.
- R4: Mode 01 counts all 16 bits. When the count rolls over from all ones to zero, the channel's overflow flag is set. Writing the run bit leaves the count bytes unchanged.
- R5: In mode 10 only the low byte counts. When it rolls over from 0xFF, the flag is set and the low byte is loaded from the high byte. The high byte is not changed.
- R6: Channel 1 in mode 11 holds both of its count bytes, whatever its run and gate bits are.
- R7: Channel 0 in mode 11 works as two counters. Its low byte is an 8-bit counter that uses channel 0's source, gate, run bit and flag. Its high byte counts machine-cycle pulses while channel 1's run bit is 1, and sets channel 1's flag when it rolls over. While this holds, channel 1's own rollovers do not set that flag.
- R8: With the source bit at 0, the channel advances once per mc_en pulse. With the source bit at 1, the pin is sampled on each mc_en pulse. The channel then advances on an mc_en pulse where the previous sample was 1 and the current pin value is 0.
- R9: An overflow flag stays set until a control write or an irq_ack pulse for that channel clears it. A rollover in the same cycle as an acknowledge leaves the flag set.
- R10: Write addresses are as follows: 0 for low byte 0, 1 for high byte 0, 2 for low byte 1, 3 for high byte 1, 4 for the mode byte and 5 for the control byte. A write takes priority over a count or flag update to the same byte in the same cycle.
- R11: Each mode-byte nibble is laid out as {gate, source, mode[1:0]}, with channel 0 in bits 3..0 and channel 1 in bits 7..4. The control byte is laid out as {flag1, flag0, run1, run0} in bits 3..0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mc_en | input | 1 | One-cycle machine-cycle enable |
| ext_t | input | 2 | External count pins, one per channel |
| ext_int | input | 2 | External gate pins, one per channel |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| irq_ack | input | 2 | Per-channel flag acknowledge pulse |
| ovf_flag | output | 2 | Overflow flags, bit 1 = channel 1 |
| cnt0 | output | 16 | Channel 0 count {high, low} |
| cnt1 | output | 16 | Channel 1 count {high, low} |

## Verification
The bench builds the block with its default parameters: 8-bit count bytes and a 5-bit prescaler field. Any rollover is therefore reached in a few cycles once the bytes are preloaded near all ones. This is done for the 13-bit, 16-bit, reload and split cases. Because the widths are narrow, long random runs also wrap the 8-bit split and reload counters many times. These runs mix mode, gate, pin, acknowledge and write traffic, and the bench compares every cycle against its behavioural model.

// File: rtl/tmr_pkg.sv
// Package: shared mode encoding and register addresses for the timer pair.
// Assumes a 3-bit write address and a 4-bit mode nibble per channel.
package tmr_pkg;
    typedef enum logic [1:0] {
        MD_13B    = 2'b00,
        MD_16B    = 2'b01,
        MD_RELOAD = 2'b10,
        MD_SPLIT  = 2'b11
    } tmr_mode_e;

    localparam int NIB_W     = 4;
    localparam int A_LO0     = 0;
    localparam int A_HI0     = 1;
    localparam int A_LO1     = 2;
    localparam int A_HI1     = 3;
    localparam int A_MODE    = 4;
    localparam int A_CTRL    = 5;
    localparam int CB_RUN0   = 0;
    localparam int CB_RUN1   = 1;
    localparam int CB_FLAG0  = 2;
    localparam int CB_FLAG1  = 3;
endpackage

// File: rtl/tmr_edge.sv
// Module: samples one external count pin on each machine-cycle enable and
// flags a falling edge between the stored sample and the present pin value.
// Assumes the pin is already synchronous to clk.
module tmr_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic mc_en,
    input  logic pin,
    output logic fall
);
    logic samp_q;

    // Hold the last machine-cycle sample of the pin.
    always_ff @(posedge clk) begin
        if (!rst_n)     samp_q <= 1'b0;
        else if (mc_en) samp_q <= pin;
    end

    // A fall is a 1 sample followed by a 0 at the next machine cycle.
    always_comb fall = mc_en & samp_q & ~pin;
endmodule

// File: rtl/tmr_chan.sv
// Module: next-state count logic for one channel, purely combinational.
// SPLIT_EN selects whether mode 11 splits into two 8-bit counters
// (channel 0) or freezes the channel (channel 1).
// Assumes the caller has already applied run/gate/source qualification.
module tmr_chan
    import tmr_pkg::*;
#(
    parameter int BYTE_W   = 8,
    parameter int PRE_W    = 5,
    parameter bit SPLIT_EN = 1'b1
) (
    input  tmr_mode_e          mode,
    input  logic               tick_lo,
    input  logic               tick_hi,
    input  logic [BYTE_W-1:0]  lo,
    input  logic [BYTE_W-1:0]  hi,
    output logic [BYTE_W-1:0]  lo_nx,
    output logic [BYTE_W-1:0]  hi_nx,
    output logic               wrap_main,
    output logic               wrap_hi
);
    localparam int W13 = BYTE_W + PRE_W;
    localparam int W16 = 2 * BYTE_W;

    logic [W13:0]       sum13;
    logic [W16:0]       sum16;
    logic [BYTE_W:0]    sum_lo;
    logic [BYTE_W:0]    sum_hi;
    logic [BYTE_W-1:0]  s_lo_nx, s_hi_nx;
    logic               s_wrap_main, s_wrap_hi;

    // Incrementers for each count width.
    always_comb begin
        sum13  = {1'b0, hi, lo[PRE_W-1:0]} + (W13+1)'(1);
        sum16  = {1'b0, hi, lo} + (W16+1)'(1);
        sum_lo = {1'b0, lo} + (BYTE_W+1)'(1);
        sum_hi = {1'b0, hi} + (BYTE_W+1)'(1);
    end

    // Split-mode behaviour chosen by SPLIT_EN.
    generate
        if (SPLIT_EN) begin : g_split
            always_comb begin
                s_lo_nx     = tick_lo ? sum_lo[BYTE_W-1:0] : lo;
                s_wrap_main = tick_lo & sum_lo[BYTE_W];
                s_hi_nx     = tick_hi ? sum_hi[BYTE_W-1:0] : hi;
                s_wrap_hi   = tick_hi & sum_hi[BYTE_W];
            end
        end else begin : g_hold
            always_comb begin
                s_lo_nx     = lo;
                s_hi_nx     = hi;
                s_wrap_main = 1'b0;
                s_wrap_hi   = 1'b0;
            end
        end
    endgenerate

    // Mode multiplexer for the next count and rollover events.
    always_comb begin
        lo_nx     = lo;
        hi_nx     = hi;
        wrap_main = 1'b0;
        wrap_hi   = 1'b0;
        unique case (mode)
            MD_13B: if (tick_lo) begin
                lo_nx     = {lo[BYTE_W-1:PRE_W], sum13[PRE_W-1:0]};
                hi_nx     = sum13[W13-1:PRE_W];
                wrap_main = sum13[W13];
            end
            MD_16B: if (tick_lo) begin
                lo_nx     = sum16[BYTE_W-1:0];
                hi_nx     = sum16[W16-1:BYTE_W];
                wrap_main = sum16[W16];
            end
            MD_RELOAD: if (tick_lo) begin
                lo_nx     = sum_lo[BYTE_W] ? hi : sum_lo[BYTE_W-1:0];
                wrap_main = sum_lo[BYTE_W];
            end
            MD_SPLIT: begin
                lo_nx     = s_lo_nx;
                hi_nx     = s_hi_nx;
                wrap_main = s_wrap_main;
                wrap_hi   = s_wrap_hi;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/dual_tmr_ctr.sv
// Module: top of the two-channel timer/counter. Holds the count bytes, the
// mode byte, the run bits and the overflow flags, qualifies counting with
// run/gate/source, and applies register writes with priority over counting.
// Assumes mc_en is a single-cycle pulse and all inputs are synchronous.
module dual_tmr_ctr
    import tmr_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int PRE_W  = 5,
    parameter int ADDR_W = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 mc_en,
    input  logic [1:0]           ext_t,
    input  logic [1:0]           ext_int,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [BYTE_W-1:0]    wr_data,
    input  logic [1:0]           irq_ack,
    output logic [1:0]           ovf_flag,
    output logic [2*BYTE_W-1:0]  cnt0,
    output logic [2*BYTE_W-1:0]  cnt1
);
    localparam int NCH = 2;

    logic [BYTE_W-1:0]     lo_q [NCH];
    logic [BYTE_W-1:0]     hi_q [NCH];
    logic [BYTE_W-1:0]     lo_nx [NCH];
    logic [BYTE_W-1:0]     hi_nx [NCH];
    logic [NCH*NIB_W-1:0]  mode_q;
    logic [NCH-1:0]        run_q;
    logic [NCH-1:0]        flag_q;
    logic [NCH-1:0]        fall, tick, wrap_main, wrap_hi;
    tmr_mode_e             md [NCH];
    logic [NCH-1:0]        set_ev;
    logic                  wr_mode, wr_ctrl;
    logic [NCH-1:0]        wr_lo, wr_hi;
    logic                  past_ok;

    // Decode of the write strobe per register.
    always_comb begin
        wr_mode = wr_en && (wr_addr == ADDR_W'(A_MODE));
        wr_ctrl = wr_en && (wr_addr == ADDR_W'(A_CTRL));
        wr_lo[0] = wr_en && (wr_addr == ADDR_W'(A_LO0));
        wr_hi[0] = wr_en && (wr_addr == ADDR_W'(A_HI0));
        wr_lo[1] = wr_en && (wr_addr == ADDR_W'(A_LO1));
        wr_hi[1] = wr_en && (wr_addr == ADDR_W'(A_HI1));
    end

    // Per-channel edge detector, enable qualification and count logic.
    generate
        for (genvar c = 0; c < NCH; c++) begin : g_ch
            logic gate_b, src_b;

            tmr_edge u_edge (
                .clk   (clk),
                .rst_n (rst_n),
                .mc_en (mc_en),
                .pin   (ext_t[c]),
                .fall  (fall[c])
            );

            // Mode fields of this channel's nibble.
            always_comb begin
                md[c]  = tmr_mode_e'(mode_q[c*NIB_W +: 2]);
                src_b  = mode_q[c*NIB_W + 2];
                gate_b = mode_q[c*NIB_W + 3];
            end

            // Qualified count tick: run, gate and source select.
            always_comb
                tick[c] = run_q[c] & (~gate_b | ext_int[c]) & (src_b ? fall[c] : mc_en);

            tmr_chan #(
                .BYTE_W   (BYTE_W),
                .PRE_W    (PRE_W),
                .SPLIT_EN (c == 0)
            ) u_chan (
                .mode      (md[c]),
                .tick_lo   (tick[c]),
                .tick_hi   (mc_en & run_q[1]),
                .lo        (lo_q[c]),
                .hi        (hi_q[c]),
                .lo_nx     (lo_nx[c]),
                .hi_nx     (hi_nx[c]),
                .wrap_main (wrap_main[c]),
                .wrap_hi   (wrap_hi[c])
            );

            // Count bytes: a write beats the count update.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    lo_q[c] <= '0;
                    hi_q[c] <= '0;
                end else begin
                    lo_q[c] <= wr_lo[c] ? wr_data : lo_nx[c];
                    hi_q[c] <= wr_hi[c] ? wr_data : hi_nx[c];
                end
            end
        end
    endgenerate

    // Flag set sources; channel 0 split mode steals channel 1's flag.
    always_comb begin
        set_ev[0] = wrap_main[0];
        set_ev[1] = (md[0] == MD_SPLIT) ? wrap_hi[0] : wrap_main[1];
    end

    // Mode byte, run bits and sticky overflow flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            run_q  <= '0;
            flag_q <= '0;
        end else begin
            if (wr_mode) mode_q <= wr_data[NCH*NIB_W-1:0];
            for (int c = 0; c < NCH; c++) begin
                if (set_ev[c])       flag_q[c] <= 1'b1;
                else if (irq_ack[c]) flag_q[c] <= 1'b0;
            end
            if (wr_ctrl) begin
                run_q  <= {wr_data[CB_RUN1], wr_data[CB_RUN0]};
                flag_q <= {wr_data[CB_FLAG1], wr_data[CB_FLAG0]};
            end
        end
    end

    // Output assembly.
    always_comb begin
        ovf_flag = flag_q;
        cnt0     = {hi_q[0], lo_q[0]};
        cnt1     = {hi_q[1], lo_q[1]};
    end

    // Marks that one full cycle out of reset has passed, for $past checks.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // R2: prescaler-mode counting leaves the top low-byte bits alone.
    p_upper_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(md[0] == MD_13B && !wr_en))
        |-> lo_q[0][BYTE_W-1:PRE_W] == $past(lo_q[0][BYTE_W-1:PRE_W]));

    // R3: gated channel with pin low does not move.
    p_gate_block_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(mode_q[3] && !ext_int[0] && md[0] != MD_SPLIT && !wr_en))
        |-> cnt0 == $past(cnt0));

    // R5: reload rollover copies the high byte into the low byte.
    p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(md[0] == MD_RELOAD && set_ev[0] && !wr_en))
        |-> (lo_q[0] == $past(hi_q[0])) && (hi_q[0] == $past(hi_q[0])) && flag_q[0]);

    // R6: channel 1 in split mode is frozen.
    p_ch1_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(md[1] == MD_SPLIT && !wr_en)) |-> cnt1 == $past(cnt1));

    // R7: channel 0's high half only moves with mc_en and channel 1's run bit.
    p_split_hi_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(md[0] == MD_SPLIT && !wr_en && !(mc_en && run_q[1])))
        |-> hi_q[0] == $past(hi_q[0]));

    // R9: a set flag stays set without acknowledge or control write.
    p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(flag_q[0] && !irq_ack[0] && !wr_ctrl)) |-> flag_q[0]);
endmodule

// File: tb/dual_tmr_ctr_tb.sv
module dual_tmr_ctr_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mc_en = 1'b0;
    logic [1:0]  ext_t = '0;
    logic [1:0]  ext_int = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [1:0]  irq_ack = '0;
    logic [1:0]  ovf_flag;
    logic [15:0] cnt0, cnt1;

    int n_vec = 0, n_bad = 0, cyc = 0;
    string cur_req = "R1";

    // Behavioural reference state.
    int m_lo[2], m_hi[2], m_fl[2], m_run[2], m_mode, m_samp[2];

    dual_tmr_ctr u_dut (
        .clk(clk), .rst_n(rst_n), .mc_en(mc_en), .ext_t(ext_t),
        .ext_int(ext_int), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .irq_ack(irq_ack), .ovf_flag(ovf_flag),
        .cnt0(cnt0), .cnt1(cnt1)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Modes 00/01/10 for one channel; returns 1 on rollover.
    function automatic bit step_std(int m, bit tk, ref int lo, ref int hi);
        int v;
        if (!tk) return 1'b0;
        case (m)
            0: begin
                v = hi * 32 + (lo % 32) + 1;
                if (v == 8192) v = 0;
                hi = v / 32; lo = (lo / 32) * 32 + (v % 32);
                return v == 0;
            end
            1: begin
                v = (hi * 256 + lo + 1) % 65536;
                hi = v / 256; lo = v % 256;
                return v == 0;
            end
            default: begin
                if (lo == 255) begin lo = hi; return 1'b1; end
                lo = lo + 1; return 1'b0;
            end
        endcase
    endfunction

    // Reference model updated at each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < 2; c++) begin
                m_lo[c] = 0; m_hi[c] = 0; m_fl[c] = 0; m_run[c] = 0; m_samp[c] = 0;
            end
            m_mode = 0;
        end else begin
            bit tk[2];
            bit s0, s1, s1b;
            int md0, md1;
            s0 = 0; s1 = 0; s1b = 0;
            for (int c = 0; c < 2; c++) begin
                int nib;
                bit src;
                nib = (m_mode >> (4*c)) & 15;
                src = (nib & 4) ? (mc_en && m_samp[c] == 1 && !ext_t[c]) : mc_en;
                tk[c] = (m_run[c] != 0) && (!(nib & 8) || ext_int[c]) && src;
            end
            md0 = m_mode & 3; md1 = (m_mode >> 4) & 3;
            if (md0 == 3) begin
                if (tk[0]) begin
                    s0 = (m_lo[0] == 255); m_lo[0] = (m_lo[0] + 1) % 256;
                end
                if (mc_en && m_run[1] != 0) begin
                    s1 = (m_hi[0] == 255); m_hi[0] = (m_hi[0] + 1) % 256;
                end
            end else begin
                s0 = step_std(md0, tk[0], m_lo[0], m_hi[0]);
            end
            if (md1 != 3) s1b = step_std(md1, tk[1], m_lo[1], m_hi[1]);
            if (md0 != 3) s1 = s1b;
            if (mc_en) begin m_samp[0] = ext_t[0]; m_samp[1] = ext_t[1]; end
            if (s0) m_fl[0] = 1; else if (irq_ack[0]) m_fl[0] = 0;
            if (s1) m_fl[1] = 1; else if (irq_ack[1]) m_fl[1] = 0;
            if (wr_en) begin
                case (wr_addr)
                    0: m_lo[0] = wr_data;
                    1: m_hi[0] = wr_data;
                    2: m_lo[1] = wr_data;
                    3: m_hi[1] = wr_data;
                    4: m_mode = wr_data;
                    5: begin
                        m_run[0] = wr_data[0]; m_run[1] = wr_data[1];
                        m_fl[0]  = wr_data[2]; m_fl[1]  = wr_data[3];
                    end
                    default: ;
                endcase
            end
        end
    end

    // Compare on every falling edge once reset has been applied.
    always @(negedge clk) begin
        if (cyc > 1) begin
            logic [15:0] e0, e1;
            logic [1:0]  ef;
            e0 = 16'(m_hi[0] * 256 + m_lo[0]);
            e1 = 16'(m_hi[1] * 256 + m_lo[1]);
            ef = {m_fl[1] != 0, m_fl[0] != 0};
            n_vec++;
            if (cnt0 !== e0 || cnt1 !== e1 || ovf_flag !== ef) begin
                n_bad++;
                $display("FAIL %s cyc %0d: cnt0=%h cnt1=%h flag=%b expected cnt0=%h cnt1=%h flag=%b",
                         cur_req, cyc, cnt0, cnt1, ovf_flag, e0, e1, ef);
            end
        end
    end

    // Watchdog and cycle counter.
    always @(posedge clk) begin
        cyc++;
        if (cyc == WATCHDOG) begin
            n_bad++;
            $display("FAIL watchdog expired at cycle %0d, expected completion", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'(a); wr_data = 8'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); mc_en = 1'b1;
            @(negedge clk); mc_en = 1'b0;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cur_req = "R1"; repeat (2) @(negedge clk);

        // R2: 13-bit mode, top three low bits preserved, rollover.
        cur_req = "R2";
        wr(4, 8'h00); wr(1, 8'hFF); wr(0, 8'hFE); wr(5, 8'h01);
        tick(4);
        // R9: flag sticky, acknowledge clears.
        cur_req = "R9";
        repeat (3) @(negedge clk);
        irq_ack = 2'b01; @(negedge clk); irq_ack = 2'b00; @(negedge clk);

        // R4: 16-bit mode; setting run keeps the count.
        cur_req = "R4";
        wr(5, 8'h00); wr(4, 8'h01); wr(1, 8'hFF); wr(0, 8'hFD);
        wr(5, 8'h01); tick(5);

        // R3: gate blocks until ext_int high.
        cur_req = "R3";
        wr(4, 8'h09); tick(3);
        ext_int[0] = 1'b1; tick(3); ext_int[0] = 1'b0;

        // R5: reload mode.
        cur_req = "R5";
        wr(4, 8'h02); wr(1, 8'hA0); wr(0, 8'hFE); wr(5, 8'h01); tick(6);

        // R8: counter source on falling edges of ext_t.
        cur_req = "R8";
        wr(4, 8'h05); wr(5, 8'h01);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk); ext_t[0] = ~ext_t[0]; tick(1);
        end

        // R6: channel 1 frozen in mode 11.
        cur_req = "R6";
        wr(4, 8'h31); wr(2, 8'h33); wr(3, 8'h44); wr(5, 8'h03); tick(5);

        // R7: channel 0 split; high half drives channel 1's flag.
        cur_req = "R7";
        wr(4, 8'h13); wr(1, 8'hFD); wr(0, 8'hFE); wr(3, 8'hFF); wr(2, 8'hFF);
        wr(5, 8'h03); tick(5);
        wr(5, 8'h01); tick(3);

        // R10: write versus count in the same cycle; R9 set beats ack.
        cur_req = "R10";
        wr(4, 8'h11); wr(5, 8'h03);
        @(negedge clk); mc_en = 1'b1; wr_en = 1'b1; wr_addr = 3'd0; wr_data = 8'h5A;
        @(negedge clk); mc_en = 1'b1; wr_addr = 3'd5; wr_data = 8'h03;
        @(negedge clk); mc_en = 1'b0; wr_en = 1'b0;
        wr(1, 8'hFF); wr(0, 8'hFF);
        @(negedge clk); mc_en = 1'b1; irq_ack = 2'b01;
        @(negedge clk); mc_en = 1'b0; irq_ack = 2'b00;

        // R11 and the rest: random traffic across all modes.
        cur_req = "R11";
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            mc_en   = ($urandom % 3) == 0;
            ext_t   = 2'($urandom);
            ext_int = 2'($urandom);
            irq_ack = (($urandom % 16) == 0) ? 2'($urandom) : 2'b00;
            wr_en   = ($urandom % 12) == 0;
            wr_addr = 3'($urandom % 6);
            wr_data = 8'($urandom);
            if (wr_addr == 3'd0 || wr_addr == 3'd2) wr_data = 8'hF0 | 8'($urandom);
        end
        @(negedge clk); wr_en = 1'b0; mc_en = 1'b0; irq_ack = 2'b00;
        @(negedge clk); @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule